// File: doc/BRIEF.md
# Watchdog Timer with Keyed Service

This block supervises software by counting down a programmable number of half-second periods. Once software sets the enable bit in the control register, the countdown runs on a slow tick-enable input. Software keeps it alive by writing an ordered pair of key words to the service register, which reloads the count from the timeout field. If the count runs out, the block raises either an internal reset request or an active-low external reset pin, as selected by a routing bit. Two active-low force bits in the control register raise either reset output at once, without waiting for a timeout.

Writes arrive on a single valid/ready port with a one-bit register select. The block never applies back-pressure: `wr_ready` is high whenever reset is released, and each cycle with `wr_valid` high is one complete write. The countdown holds while the debug or low-power input is high and the matching suspend bit is set. Both reset outputs stay asserted until the block's own reset clears them.

Top module: `wdk_top`

## Requirements
- R1: After reset, `ctrl_o` reads 16'h0030, `cnt_o` is 0, `int_rst_req` is 0 and `ext_rst_n` is 1.
- R2: The control layout is bit 0 low-power suspend, bit 1 debug suspend, bit 2 enable, bit 3 route-to-external, bit 4 force-internal (active-low), bit 5 force-external (active-low), bits 15:8 timeout N, and bits 7:6 read as 0. A control write (`wr_sel`=0) stores the word in the next cycle, except that the enable bit can only go from 0 to 1.
- R3: The control write that first sets the enable bit loads `cnt_o` with that write's timeout field.
- R4: A service write (`wr_sel`=1) of 16'hAAAA reloads `cnt_o` from the stored timeout field only if the previous service write was 16'h5555. A lone 16'hAAAA changes nothing.
- R5: A service write of any value other than 16'h5555 or a completing 16'hAAAA clears the armed key state. Control writes leave the key state unchanged.
- R6: While enabled and not halted, each cycle with `tick_2hz` high decrements a nonzero `cnt_o` by one. While disabled the count holds.
- R7: A tick with `cnt_o` at 0 expires the watchdog, so expiry comes on tick N+1 after a reload. Expiry sets `int_rst_req` when the route bit is 0 and pulls `ext_rst_n` low when it is 1.
- R8: With `dbg_mode` high and debug suspend set, or with `lp_mode` high and low-power suspend set, ticks do not change `cnt_o`.
- R9: A control write with bit 4 at 0 sets `int_rst_req` in the next cycle. A control write with bit 5 at 0 pulls `ext_rst_n` low in the next cycle.
- R10: Once asserted, `int_rst_req` and `ext_rst_n` hold until `rst_n` goes low, and the countdown stops.
- R11: Rewriting the timeout after enable does not change `cnt_o`. The new value is used at the next reload.
- R12: `wr_ready` is 1 whenever `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write accepted (always 1 out of reset) |
| wr_sel | input | 1 | 0 selects control, 1 selects service |
| wr_data | input | 16 | Write data |
| tick_2hz | input | 1 | Half-second tick enable |
| dbg_mode | input | 1 | System in debug halt |
| lp_mode | input | 1 | System in low-power state |
| int_rst_req | output | 1 | Internal reset request, sticky |
| ext_rst_n | output | 1 | External reset, active-low, sticky |
| cnt_o | output | 8 | Remaining ticks before expiry |
| ctrl_o | output | 16 | Stored control word |

## Verification
The bench attacks the key detector with broken pairs (a wrong word between the keys, a lone second key, a control write between the keys). A detector that does not disarm reloads when it should not, and one that disarms on control writes misses a valid reload. It checks that expiry comes on exactly tick N+1 and goes to the selected output. An off-by-one counter expires a tick early or late, and a swapped route drives the wrong pin. It also checks that enable stays set, that a timeout rewrite leaves the live count alone, and that the outputs stay asserted. A design that let enable clear, loaded the new timeout at once, or let the reset outputs fall would show it on `ctrl_o`, `cnt_o` or the reset pins.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int B_SLP    = 0;
  localparam int B_SDBG   = 1;
  localparam int B_EN     = 2;
  localparam int B_ROUTE  = 3;
  localparam int B_FINT_N = 4;
  localparam int B_FEXT_N = 5;
  localparam int N_FLAGS  = 6;

  typedef enum logic {KEY_IDLE = 1'b0, KEY_ARMED = 1'b1} key_state_e;
endpackage

// File: rtl/wdk_ctrl_reg.sv
module wdk_ctrl_reg
  import wdk_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctrl_q,
  output logic          en_load,
  output logic          force_int,
  output logic          force_ext
);
  localparam int GAP = DW - TW - N_FLAGS;
  localparam logic [DW-1:0] MASK = {{TW{1'b1}}, {GAP{1'b0}}, {N_FLAGS{1'b1}}};
  localparam logic [DW-1:0] RST_VAL = DW'((1 << B_FINT_N) | (1 << B_FEXT_N));

  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d       = wr_data & MASK;
      ctrl_d[B_EN] = ctrl_q[B_EN] | wr_data[B_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RST_VAL;
    else        ctrl_q <= ctrl_d;
  end

  assign en_load   = wr_ctrl & ~ctrl_q[B_EN] & wr_data[B_EN];
  assign force_int = wr_ctrl & ~wr_data[B_FINT_N];
  assign force_ext = wr_ctrl & ~wr_data[B_FEXT_N];
endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int              DW    = 16,
  parameter logic [DW-1:0]   KEY_A = 16'h5555,
  parameter logic [DW-1:0]   KEY_B = 16'hAAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_svc,
  input  logic [DW-1:0] wr_data,
  output logic          reload
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_svc) st_d = (wr_data == KEY_A) ? KEY_ARMED : KEY_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end

  assign reload = wr_svc && (st_q == KEY_ARMED) && (wr_data == KEY_B);
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          step,
  output logic [TW-1:0] cnt_q,
  output logic          expire
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = step & at_zero & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (step && !at_zero)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdk_rst_out.sv
module wdk_rst_out (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic route_ext,
  input  logic force_int,
  input  logic force_ext,
  output logic int_req,
  output logic ext_n,
  output logic halted
);
  logic int_q, ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      int_q <= int_q | force_int | (expire & ~route_ext);
      ext_q <= ext_q | force_ext | (expire &  route_ext);
    end
  end

  assign int_req = int_q;
  assign ext_n   = ~ext_q;
  assign halted  = int_q | ext_q;
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int            DW    = 16,
  parameter int            TW    = 8,
  parameter logic [DW-1:0] KEY_A = 16'h5555,
  parameter logic [DW-1:0] KEY_B = 16'hAAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          tick_2hz,
  input  logic          dbg_mode,
  input  logic          lp_mode,
  output logic          int_rst_req,
  output logic          ext_rst_n,
  output logic [TW-1:0] cnt_o,
  output logic [DW-1:0] ctrl_o
);
  localparam int TO_LSB = DW - TW;

  logic [DW-1:0] ctrl_q;
  logic wr_ctrl, wr_svc, en_load, force_int, force_ext, reload;
  logic hold, halted, step, expire, load;
  logic [TW-1:0] load_val;

  assign wr_ready = rst_n;
  assign wr_ctrl  = wr_valid & ~wr_sel;
  assign wr_svc   = wr_valid &  wr_sel;

  wdk_ctrl_reg #(.DW(DW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .en_load(en_load), .force_int(force_int), .force_ext(force_ext)
  );

  wdk_keyseq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .wr_data(wr_data), .reload(reload)
  );

  assign hold     = (dbg_mode & ctrl_q[B_SDBG]) | (lp_mode & ctrl_q[B_SLP]);
  assign step     = ctrl_q[B_EN] & tick_2hz & ~hold & ~halted;
  assign load     = en_load | reload;
  assign load_val = en_load ? wr_data[DW-1:TO_LSB] : ctrl_q[DW-1:TO_LSB];

  wdk_countdown #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .step(step), .cnt_q(cnt_o), .expire(expire)
  );

  wdk_rst_out u_rst (
    .clk(clk), .rst_n(rst_n), .expire(expire), .route_ext(ctrl_q[B_ROUTE]),
    .force_int(force_int), .force_ext(force_ext),
    .int_req(int_rst_req), .ext_n(ext_rst_n), .halted(halted)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
  import wdk_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          tick_2hz,
  input logic          dbg_mode,
  input logic          lp_mode,
  input logic          int_rst_req,
  input logic          ext_rst_n,
  input logic [TW-1:0] cnt_o,
  input logic [DW-1:0] ctrl_o
);
  logic live;
  assign live = ctrl_o[B_EN] && !int_rst_req && ext_rst_n && !wr_valid &&
                !((dbg_mode && ctrl_o[B_SDBG]) || (lp_mode && ctrl_o[B_SLP]));

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[B_EN] |=> ctrl_o[B_EN]); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tick_2hz && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[B_EN] && !wr_valid) |=> $stable(cnt_o)); // R6
  AST_EXPIRE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tick_2hz && cnt_o == '0) |=> (ctrl_o[B_ROUTE] ? !ext_rst_n : int_rst_req)); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (((dbg_mode && ctrl_o[B_SDBG]) || (lp_mode && ctrl_o[B_SLP])) && !wr_valid) |=> $stable(cnt_o)); // R8
  AST_FORCE_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_sel && !wr_data[B_FINT_N]) |=> int_rst_req); // R9
  AST_FORCE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_sel && !wr_data[B_FEXT_N]) |=> !ext_rst_n); // R9
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_req |=> int_rst_req); // R10
  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |=> !ext_rst_n); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_rst_req || !ext_rst_n) && !wr_valid) |=> $stable(cnt_o)); // R10
  AST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready); // R12
endmodule

bind wdk_top wdk_checker #(.DW(DW), .TW(TW)) u_wdk_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_sel(wr_sel), .wr_data(wr_data), .tick_2hz(tick_2hz),
  .dbg_mode(dbg_mode), .lp_mode(lp_mode), .int_rst_req(int_rst_req),
  .ext_rst_n(ext_rst_n), .cnt_o(cnt_o), .ctrl_o(ctrl_o)
);

// File: tb/tb_wdk_top.sv
module tb_wdk_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic tick_2hz = 1'b0, dbg_mode = 1'b0, lp_mode = 1'b0;
  logic wr_ready, int_rst_req, ext_rst_n;
  logic [7:0] cnt_o;
  logic [15:0] ctrl_o;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  // reference model, built from the requirements
  logic [15:0] m_ctrl;
  logic [7:0]  m_cnt;
  logic        m_arm, m_int, m_ext_n;

  always #4 clk = ~clk;

  wdk_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick_2hz(tick_2hz),
    .dbg_mode(dbg_mode), .lp_mode(lp_mode), .int_rst_req(int_rst_req),
    .ext_rst_n(ext_rst_n), .cnt_o(cnt_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [15:0] ctrl_next(logic [15:0] cur, logic [15:0] d);
    logic [15:0] n;
    n    = d & 16'hFF3F;
    n[2] = cur[2] | d[2];
    return n;
  endfunction

  function automatic logic is_held(logic [15:0] c, logic dbg, logic lp);
    return (dbg && c[1]) || (lp && c[0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= 16'h0030; m_cnt <= 8'd0; m_arm <= 1'b0;
      m_int <= 1'b0; m_ext_n <= 1'b1;
    end else begin
      logic nint, next_n, ld, rl;
      nint = m_int; next_n = m_ext_n; ld = 1'b0; rl = 1'b0;
      if (wr_valid && !wr_sel) begin
        m_ctrl <= ctrl_next(m_ctrl, wr_data);
        ld = !m_ctrl[2] && wr_data[2];
        if (!wr_data[4]) nint = 1'b1;
        if (!wr_data[5]) next_n = 1'b0;
      end
      if (wr_valid && wr_sel) begin
        rl = m_arm && (wr_data == 16'hAAAA);
        m_arm <= (wr_data == 16'h5555);
      end
      if (ld) m_cnt <= wr_data[15:8];
      else if (rl) m_cnt <= m_ctrl[15:8];
      else if (m_ctrl[2] && tick_2hz && !is_held(m_ctrl, dbg_mode, lp_mode)
               && !m_int && m_ext_n) begin
        if (m_cnt == 0) begin
          if (m_ctrl[3]) next_n = 1'b0; else nint = 1'b1;
        end else m_cnt <= m_cnt - 1'b1;
      end
      m_int <= nint; m_ext_n <= next_n;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk("R2 ctrl_o", ctrl_o, m_ctrl);
    chk("R6 cnt_o", {8'h0, cnt_o}, {8'h0, m_cnt});
    chk("R7 int_rst_req", {15'h0, int_rst_req}, {15'h0, m_int});
    chk("R9 ext_rst_n", {15'h0, ext_rst_n}, {15'h0, m_ext_n});
    chk("R12 wr_ready", {15'h0, wr_ready}, 16'h1);
  end

  task automatic wr(logic sel, logic [15:0] d);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_2hz = 1'b1; @(negedge clk); tick_2hz = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R1 ctrl_o", ctrl_o, 16'h0030);
    chk("R1 cnt_o", {8'h0, cnt_o}, 16'h0);
    chk("R1 int_rst_req", {15'h0, int_rst_req}, 16'h0);
    chk("R1 ext_rst_n", {15'h0, ext_rst_n}, 16'h1);
    rst_n = 1'b1; @(negedge clk);
    cmp_on = 1'b1;
    chk("R12 wr_ready", {15'h0, wr_ready}, 16'h1);

    ticks(2);
    chk("R6 disabled hold", {8'h0, cnt_o}, 16'h0);
    wr(1'b0, 16'h03F4);
    chk("R2 layout", ctrl_o, 16'h0334);
    chk("R3 enable load", {8'h0, cnt_o}, 16'h3);
    wr(1'b0, 16'h0230);
    chk("R2 enable sticky", ctrl_o, 16'h0234);
    chk("R11 no live change", {8'h0, cnt_o}, 16'h3);
    ticks(2);
    chk("R6 decrement", {8'h0, cnt_o}, 16'h1);
    wr(1'b1, 16'hAAAA);
    chk("R4 lone second key", {8'h0, cnt_o}, 16'h1);
    wr(1'b1, 16'h5555); wr(1'b1, 16'h1234); wr(1'b1, 16'hAAAA);
    chk("R5 broken pair", {8'h0, cnt_o}, 16'h1);
    wr(1'b1, 16'h5555); wr(1'b0, 16'h0236); wr(1'b1, 16'hAAAA);
    chk("R4 R5 R11 reload", {8'h0, cnt_o}, 16'h2);
    dbg_mode = 1'b1; ticks(3); dbg_mode = 1'b0;
    chk("R8 debug suspend", {8'h0, cnt_o}, 16'h2);
    ticks(2);
    chk("R7 at zero", {15'h0, int_rst_req}, 16'h0);
    ticks(1);
    chk("R7 internal expiry", {15'h0, int_rst_req}, 16'h1);
    chk("R7 external idle", {15'h0, ext_rst_n}, 16'h1);
    wr(1'b1, 16'h5555); wr(1'b1, 16'hAAAA); ticks(3);
    chk("R10 int sticky", {15'h0, int_rst_req}, 16'h1);
    chk("R10 counter halted", {8'h0, cnt_o}, 16'h2);

    do_reset();
    wr(1'b0, 16'h003D); lp_mode = 1'b1; ticks(2); lp_mode = 1'b0;
    chk("R8 low-power suspend", {15'h0, ext_rst_n}, 16'h1);
    ticks(1);
    chk("R7 external expiry", {15'h0, ext_rst_n}, 16'h0);
    chk("R7 internal idle", {15'h0, int_rst_req}, 16'h0);

    do_reset();
    wr(1'b0, 16'h0020);
    chk("R9 force internal", {15'h0, int_rst_req}, 16'h1);
    chk("R9 ext untouched", {15'h0, ext_rst_n}, 16'h1);
    do_reset();
    wr(1'b0, 16'h0010);
    chk("R9 force external", {15'h0, ext_rst_n}, 16'h0);
    wr(1'b0, 16'h0030);
    chk("R10 ext sticky", {15'h0, ext_rst_n}, 16'h0);

    for (int blk = 0; blk < 40; blk++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        int r;
        r = int'($urandom_range(0, 99));
        wr_valid = (r < 30);
        wr_sel   = $urandom_range(0, 2) != 0;
        case ($urandom_range(0, 3))
          0: wr_data = 16'h5555;
          1: wr_data = 16'hAAAA;
          2: wr_data = 16'($urandom);
          default: wr_data = {8'($urandom_range(0, 4)), 2'b00, 2'b11, 4'($urandom)};
        endcase
        if (!wr_sel && $urandom_range(0, 7) != 0) wr_data[5:4] = 2'b11;
        tick_2hz = ($urandom_range(0, 3) == 0);
        dbg_mode = ($urandom_range(0, 4) == 0);
        lp_mode  = ($urandom_range(0, 4) == 0);
        @(negedge clk);
      end
      wr_valid = 1'b0; tick_2hz = 1'b0; dbg_mode = 1'b0; lp_mode = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule